// File: doc/BRIEF.md
# ADPCM Sample Playback Channel

This block plays one sound effect held as 4-bit ADPCM in a byte-wide sample memory. A controlling processor halts the channel, presets the first and last byte address of the effect, and then lets it run. While running, the channel produces one sample tick for every 48 pulses of a slow 375 kHz clock enable, so samples come out at 7812.5 Hz. On each tick it decodes the next nibble into a 12-bit signed PCM value and presents it together with a one-cycle valid pulse.

Each memory byte carries two nibbles. The upper nibble is decoded first. The address moves on after the lower nibble. Once the last byte has been played the address stays where it is and no further samples appear. Decoding tracks a step index that selects a step size from a fixed table. The index rises for large magnitudes and falls for small ones. The signed difference is built by shifting and adding, and the running value saturates at the 12-bit limits. The memory is assumed to return data for `mem_addr` in the same cycle.

Top module: `adpcm_voice`

## Requirements
- R1: While the channel is halted, whether after `rst_n` or after a halt write, `pcm_out` is 0 and `pcm_valid` stays low. A halt also returns the running value and the step index to 0.
- R2: After a run write, a decode happens on every 48th `slow_en` pulse. Consecutive `pcm_valid` pulses are therefore exactly 48 `slow_en` periods apart.
- R3: `mem_addr` starts at the preset start address. Bits [7:4] of a byte are decoded before bits [3:0]. The address advances by one only after the lower nibble has been decoded.
- R4: After the lower nibble of the byte at the end address has been decoded, `mem_addr` holds the end address and `pcm_valid` stays low until the channel is configured again.
- R5: The step size for index i comes from a 49-entry table. The table runs from 0x010 at index 0 to 0x610 at index 48.
- R6: If nibble bits [2:0] are 4, 5, 6 or 7, the step index rises by 2, 4, 6 or 8. Any other value lowers it by 1. The index is clamped to 0..48, and the new index applies from the following nibble on.
- R7: The difference is step>>3, plus step when bit 2 is set, plus step>>1 when bit 1 is set, plus step>>2 when bit 0 is set, with every shift truncating. Bit 3 set makes the difference negative.
- R8: The running value adds the difference and saturates to -2048..+2047. It is presented as `pcm_out` in the cycle that `pcm_valid` is high.
- R9: A halt write that lands in the same cycle as a pending decode wins. No sample is produced, the output drops to 0, and the next run starts decoding from a zero running value and index 0.
- R10: A configuration write with `cfg_we` high takes its function from `cfg_sel`: 0 halts, 1 loads the start address from `cfg_data`, 2 loads the end address, and 3 runs. Loading the end address does not move `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write function: 0 halt, 1 start, 2 end, 3 run |
| cfg_data | input | ADDR_W | Address value for start or end writes |
| slow_en | input | 1 | 375 kHz clock enable, one cycle wide |
| mem_addr | output | ADDR_W | Sample memory byte address |
| mem_data | input | 8 | Sample memory byte read at `mem_addr` |
| pcm_out | output | 12 | Decoded signed sample |
| pcm_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
Two functions can meet in one cycle: a decode that the divider has already scheduled, and a halt write from the processor. The bench drives `slow_en` by hand and counts off 48 pulses. It then places the halt write in the exact cycle in which the pending decode would be taken. It judges the result by the absence of a valid pulse, a zero output, and a restart that reproduces the first sample of a fresh decode. A second overlap, the address advance on the last byte against the end compare, is judged by the frozen address and by the silence that follows.

// File: rtl/adpcm_pkg.sv
// Shared types and the step-size table for the ADPCM playback channel.
// Assumes a 4-bit code and a 12-bit signed result.
package adpcm_pkg;
    localparam int PCM_W   = 12;
    localparam int IDX_W   = 6;
    localparam int IDX_TOP = 48;

    typedef enum logic [1:0] {
        CFG_HALT  = 2'd0,
        CFG_START = 2'd1,
        CFG_END   = 2'd2,
        CFG_RUN   = 2'd3
    } cfg_sel_e;

    // Step size selected by the step index (R5)
    function automatic logic [11:0] step_size(input logic [IDX_W-1:0] i);
        case (i)
            6'd0:  step_size = 12'h010;  6'd1:  step_size = 12'h011;
            6'd2:  step_size = 12'h013;  6'd3:  step_size = 12'h015;
            6'd4:  step_size = 12'h017;  6'd5:  step_size = 12'h019;
            6'd6:  step_size = 12'h01C;  6'd7:  step_size = 12'h01F;
            6'd8:  step_size = 12'h022;  6'd9:  step_size = 12'h025;
            6'd10: step_size = 12'h029;  6'd11: step_size = 12'h02D;
            6'd12: step_size = 12'h032;  6'd13: step_size = 12'h037;
            6'd14: step_size = 12'h03C;  6'd15: step_size = 12'h042;
            6'd16: step_size = 12'h049;  6'd17: step_size = 12'h050;
            6'd18: step_size = 12'h058;  6'd19: step_size = 12'h061;
            6'd20: step_size = 12'h06B;  6'd21: step_size = 12'h076;
            6'd22: step_size = 12'h082;  6'd23: step_size = 12'h08F;
            6'd24: step_size = 12'h09D;  6'd25: step_size = 12'h0AD;
            6'd26: step_size = 12'h0BE;  6'd27: step_size = 12'h0D1;
            6'd28: step_size = 12'h0E6;  6'd29: step_size = 12'h0FD;
            6'd30: step_size = 12'h117;  6'd31: step_size = 12'h133;
            6'd32: step_size = 12'h151;  6'd33: step_size = 12'h173;
            6'd34: step_size = 12'h198;  6'd35: step_size = 12'h1C1;
            6'd36: step_size = 12'h1EE;  6'd37: step_size = 12'h220;
            6'd38: step_size = 12'h256;  6'd39: step_size = 12'h292;
            6'd40: step_size = 12'h2D4;  6'd41: step_size = 12'h31C;
            6'd42: step_size = 12'h36C;  6'd43: step_size = 12'h3C3;
            6'd44: step_size = 12'h424;  6'd45: step_size = 12'h48E;
            6'd46: step_size = 12'h502;  6'd47: step_size = 12'h583;
            default: step_size = 12'h610;
        endcase
    endfunction
endpackage

// File: rtl/adpcm_rate_div.sv
// Sample-rate divider: emits a registered one-cycle tick on every DIV-th
// slow_en pulse. Assumes slow_en is a one-cycle enable. 'clear' restarts
// the count.
module adpcm_rate_div #(
    parameter int DIV = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic slow_en,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count enable pulses and flag the last one of each group (R2)
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (slow_en) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adpcm_fetch.sv
// Byte address sequencer with nibble selection. It holds the start and end
// presets, steps through the nibbles and freezes after the end byte.
// Assumes mem_data belongs to mem_addr in the same cycle.
module adpcm_fetch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              ld_start,
    input  logic              ld_end,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              step,
    input  logic [7:0]        mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        nibble,
    output logic              lo_half,
    output logic              frozen
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] end_q;

    // Preset registers and address advance after the lower nibble (R3, R4)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            end_q   <= '0;
            lo_half <= 1'b0;
            frozen  <= 1'b0;
        end else begin
            if (halt) begin
                lo_half <= 1'b0;
                frozen  <= 1'b0;
            end else if (step && !frozen) begin
                lo_half <= !lo_half;
                if (lo_half) begin
                    if (addr_q == end_q) frozen <= 1'b1;
                    else                 addr_q <= addr_q + 1'b1;
                end
            end
            if (ld_start) addr_q <= cfg_data;
            if (ld_end)   end_q  <= cfg_data;
        end
    end

    // Upper nibble first, lower nibble second
    assign nibble   = lo_half ? mem_data[3:0] : mem_data[7:4];
    assign mem_addr = addr_q;
endmodule

// File: rtl/adpcm_nibble_dec.sv
// Nibble decoder: step-index tracking, shift-and-add difference and a
// saturating 12-bit accumulator. 'go' decodes one nibble. 'clear' zeroes
// all state.
module adpcm_nibble_dec
    import adpcm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    go,
    input  logic [3:0]              nib,
    output logic signed [PCM_W-1:0] pcm,
    output logic                    valid,
    output logic [IDX_W-1:0]        idx
);
    localparam logic signed [13:0] POS_LIM = 14'sd2047;
    localparam logic signed [13:0] NEG_LIM = -14'sd2048;

    logic [11:0]        step;
    logic [12:0]        diff;
    logic signed [13:0] delta;
    logic signed [13:0] sum;
    logic signed [PCM_W-1:0] sat;
    logic [6:0]         grown;
    logic [IDX_W-1:0]   idx_nx;

    // Difference from the current index, with truncating shifts (R5, R7)
    always_comb begin
        step = step_size(idx);
        diff = {4'b0, step[11:3]};
        if (nib[2]) diff = diff + {1'b0, step};
        if (nib[1]) diff = diff + {2'b0, step[11:1]};
        if (nib[0]) diff = diff + {3'b0, step[11:2]};
        delta = nib[3] ? -$signed({1'b0, diff}) : $signed({1'b0, diff});
    end

    // Saturating add onto the running value (R8)
    always_comb begin
        sum = $signed({{2{pcm[PCM_W-1]}}, pcm}) + delta;
        if (sum > POS_LIM)      sat = POS_LIM[PCM_W-1:0];
        else if (sum < NEG_LIM) sat = NEG_LIM[PCM_W-1:0];
        else                    sat = sum[PCM_W-1:0];
    end

    // Index adjustment by magnitude, clamped to 0..IDX_TOP (R6)
    always_comb begin
        grown = {1'b0, idx} + {4'b0, nib[1:0], 1'b0} + 7'd2;
        if (nib[2])
            idx_nx = (grown > 7'(IDX_TOP)) ? IDX_W'(IDX_TOP) : grown[IDX_W-1:0];
        else
            idx_nx = (idx == '0) ? '0 : idx - 1'b1;
    end

    // State update on each decode
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pcm   <= '0;
            idx   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= go;
            if (go) begin
                pcm <= sat;
                idx <= idx_nx;
            end
        end
    end
endmodule

// File: rtl/adpcm_voice.sv
// ADPCM sample playback channel top. It decodes configuration writes, keeps
// the run state and joins divider, fetch and decoder. A halt write wins
// over a decode in the same cycle.
module adpcm_voice
    import adpcm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DIV    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              slow_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic [11:0]       pcm_out,
    output logic              pcm_valid
);
    logic       run_q;
    logic       halt_wr;
    logic       run_wr;
    logic       hold;
    logic       tick;
    logic       go;
    logic       lo_half;
    logic       frozen;
    logic [3:0] nib;
    logic [IDX_W-1:0] step_idx;
    logic signed [PCM_W-1:0] pcm_s;

    // Write decode (R10)
    assign halt_wr = cfg_we && (cfg_sel == CFG_HALT);
    assign run_wr  = cfg_we && (cfg_sel == CFG_RUN);
    assign hold    = !run_q || halt_wr;
    assign go      = tick && !hold && !frozen;

    // Run state: halt clears it, run sets it (R1)
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (halt_wr) run_q <= 1'b0;
        else if (run_wr)  run_q <= 1'b1;
    end

    adpcm_rate_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hold),
        .slow_en (slow_en),
        .tick    (tick)
    );

    adpcm_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (hold),
        .ld_start (cfg_we && (cfg_sel == CFG_START)),
        .ld_end   (cfg_we && (cfg_sel == CFG_END)),
        .cfg_data (cfg_data),
        .step     (go),
        .mem_data (mem_data),
        .mem_addr (mem_addr),
        .nibble   (nib),
        .lo_half  (lo_half),
        .frozen   (frozen)
    );

    adpcm_nibble_dec u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hold),
        .go    (go),
        .nib   (nib),
        .pcm   (pcm_s),
        .valid (pcm_valid),
        .idx   (step_idx)
    );

    assign pcm_out = pcm_s;
endmodule

// File: rtl/adpcm_voice_chk.sv
// Temporal checks for adpcm_voice, attached by bind. They observe ports
// and the signals passed between the sub-blocks.
module adpcm_voice_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_q,
    input logic              tick,
    input logic              lo_half,
    input logic              frozen,
    input logic [5:0]        step_idx,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [11:0]       pcm_out,
    input logic              pcm_valid
);
    // R1
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pcm_out == 12'd0) && !pcm_valid);

    // R2
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(tick));

    // R3
    addr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> ($past(cfg_we) || $past(tick && lo_half)));

    // R4
    frozen_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !cfg_we) |=> $stable(mem_addr));

    // R4
    frozen_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && $past(frozen)) |-> !pcm_valid);

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_idx <= 6'd48);
endmodule

bind adpcm_voice adpcm_voice_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .tick      (tick),
    .lo_half   (lo_half),
    .frozen    (frozen),
    .step_idx  (step_idx),
    .cfg_we    (cfg_we),
    .mem_addr  (mem_addr),
    .pcm_out   (pcm_out),
    .pcm_valid (pcm_valid)
);

// File: tb/adpcm_voice_bench.sv
// Directed bench for adpcm_voice: one task per scenario, each checking its
// own results against a reference model built from the requirements.
module adpcm_voice_bench;
    localparam int AW  = 16;
    localparam int DIV = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_data = '0;
    logic          slow_en = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic [11:0]   pcm_out;
    logic          pcm_valid;

    logic [7:0] mem [256];
    assign mem_data = mem[mem_addr[7:0]];

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit auto_en = 1'b0;
    int en_period = 1;
    int m_acc;
    int m_idx;

    localparam logic [11:0] STEPS [49] = '{
        12'h010,12'h011,12'h013,12'h015,12'h017,12'h019,12'h01C,12'h01F,
        12'h022,12'h025,12'h029,12'h02D,12'h032,12'h037,12'h03C,12'h042,
        12'h049,12'h050,12'h058,12'h061,12'h06B,12'h076,12'h082,12'h08F,
        12'h09D,12'h0AD,12'h0BE,12'h0D1,12'h0E6,12'h0FD,12'h117,12'h133,
        12'h151,12'h173,12'h198,12'h1C1,12'h1EE,12'h220,12'h256,12'h292,
        12'h2D4,12'h31C,12'h36C,12'h3C3,12'h424,12'h48E,12'h502,12'h583,
        12'h610};

    adpcm_voice #(.ADDR_W(AW), .DIV(DIV)) u_adpcm_voice (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data, .slow_en,
        .mem_addr, .mem_data, .pcm_out, .pcm_valid
    );

    always #2 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Periodic slow enable when the bench is not driving it by hand
    initial begin
        int ctr = 0;
        forever begin
            @(negedge clk);
            if (auto_en) begin
                if (ctr >= en_period - 1) begin slow_en = 1'b1; ctr = 0; end
                else begin slow_en = 1'b0; ctr++; end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R10: select codes 0 halt, 1 start, 2 end, 3 run
    task automatic cfg_write(input logic [1:0] sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = AW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Reference decode of one nibble (R5, R6, R7, R8)
    task automatic model(input logic [3:0] n, output int e);
        int st, d;
        st = int'(STEPS[m_idx]);
        d = st >> 3;
        if (n[2]) d += st;
        if (n[1]) d += st >> 1;
        if (n[0]) d += st >> 2;
        if (n[3]) d = -d;
        m_acc += d;
        if (m_acc > 2047) m_acc = 2047;
        if (m_acc < -2048) m_acc = -2048;
        if (n[2]) begin
            m_idx += 2 * (int'(n[2:0]) - 3);
            if (m_idx > 48) m_idx = 48;
        end else if (m_idx > 0) m_idx--;
        e = m_acc;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 48 * 8 + 20; i++) begin
            @(negedge clk);
            if (pcm_valid) begin got = 1'b1; break; end
        end
    endtask

    // Play start..stop and compare every sample; returns max and min seen
    task automatic play_span(input int start, input int stop, input string req,
                             output int vmax, output int vmin);
        int exp, last_cyc, a, got_int;
        bit got;
        m_acc = 0; m_idx = 0; vmax = -5000; vmin = 5000; last_cyc = -1;
        cfg_write(2'd0, 0);
        cfg_write(2'd1, start);
        cfg_write(2'd2, stop);
        check(mem_addr == AW'(start), "R10 end write keeps address", int'(mem_addr), start);
        cfg_write(2'd3, 0);
        a = start;
        while (1) begin
            for (int h = 0; h < 2; h++) begin
                logic [3:0] n;
                n = (h == 0) ? mem[a][7:4] : mem[a][3:0];
                model(n, exp);
                wait_valid(got);
                check(got, "R2 sample produced", int'(got), 1);
                got_int = int'($signed(pcm_out));
                check(got_int == exp, req, got_int, exp);
                if (got_int > vmax) vmax = got_int;
                if (got_int < vmin) vmin = got_int;
                if (last_cyc >= 0)
                    check(cyc - last_cyc == DIV * en_period, "R2 sample spacing",
                          cyc - last_cyc, DIV * en_period);
                last_cyc = cyc;
                if (h == 0)
                    check(mem_addr == AW'(a), "R3 upper nibble address", int'(mem_addr), a);
                else
                    check(mem_addr == AW'((a == stop) ? a : a + 1), "R3 advance after lower nibble",
                          int'(mem_addr), (a == stop) ? a : a + 1);
            end
            if (a == stop) break;
            a = (a + 1) & 8'hFF;
        end
    endtask

    // Confirm silence and a frozen address after the end byte (R4)
    task automatic check_frozen(input int stop);
        int seen = 0;
        for (int i = 0; i < 3 * DIV * en_period; i++) begin
            @(negedge clk);
            if (pcm_valid) seen++;
        end
        check(seen == 0, "R4 no samples after end", seen, 0);
        check(mem_addr == AW'(stop), "R4 address frozen at end", int'(mem_addr), stop);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pcm_out == 12'd0, "R1 output zero after reset", int'(pcm_out), 0);
        check(!pcm_valid, "R1 no valid after reset", int'(pcm_valid), 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pcm_valid || pcm_out != 0) break;
        end
        check(pcm_out == 12'd0 && !pcm_valid, "R1 quiet while halted", int'(pcm_out), 0);
    endtask

    task automatic t_mixed();
        int mx, mn;
        mem[0] = 8'h00;
        mem[1] = 8'h08;
        for (int i = 2; i < 24; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
        en_period = 3; auto_en = 1'b1;
        play_span(0, 23, "R5 R6 R7 mixed codes", mx, mn);
        check_frozen(23);
        auto_en = 1'b0; slow_en = 1'b0;
    endtask

    task automatic t_saturate();
        int mx, mn;
        for (int i = 8'h60; i < 8'h70; i++) mem[i] = 8'h77;
        for (int i = 8'h70; i < 8'h80; i++) mem[i] = 8'hFF;
        en_period = 1; auto_en = 1'b1;
        play_span(8'h60, 8'h7F, "R8 saturating sequence", mx, mn);
        check(mx == 2047, "R8 positive limit reached", mx, 2047);
        check(mn == -2048, "R8 negative limit reached", mn, -2048);
        check_frozen(8'h7F);
        auto_en = 1'b0; slow_en = 1'b0;
    endtask

    task automatic t_single_byte();
        int mx, mn;
        mem[8'hA0] = 8'hC3;
        en_period = 2; auto_en = 1'b1;
        play_span(8'hA0, 8'hA0, "R4 start equals end", mx, mn);
        check_frozen(8'hA0);
        auto_en = 1'b0; slow_en = 1'b0;
    endtask

    task automatic pulse_en(input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk); slow_en = 1'b1;
            @(negedge clk); slow_en = 1'b0;
        end
    endtask

    // R9: halt write in the very cycle a decode is pending
    task automatic t_halt_collide();
        auto_en = 1'b0; slow_en = 1'b0;
        mem[8'h40] = 8'h5A; mem[8'h41] = 8'h33;
        cfg_write(2'd0, 0);
        cfg_write(2'd1, 8'h40);
        cfg_write(2'd2, 8'h41);
        cfg_write(2'd3, 0);
        pulse_en(DIV);
        @(negedge clk);
        check(pcm_valid && $signed(pcm_out) == 22, "R9 first sample before collision",
              int'($signed(pcm_out)), 22);
        pulse_en(DIV);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = '0;
        @(negedge clk);
        cfg_we = 1'b0;
        check(!pcm_valid, "R9 halt beats decode valid", int'(pcm_valid), 0);
        check(pcm_out == 12'd0, "R9 output cleared by halt", int'(pcm_out), 0);
        cfg_write(2'd1, 8'h40);
        cfg_write(2'd3, 0);
        pulse_en(DIV);
        @(negedge clk);
        check(pcm_valid && $signed(pcm_out) == 22, "R9 restart from zero state",
              int'($signed(pcm_out)), 22);
        check(mem_addr == AW'(8'h40), "R9 R3 restart address", int'(mem_addr), 8'h40);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cyc >= 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mixed();
        t_saturate();
        t_single_byte();
        t_halt_collide();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule